// File: doc/BRIEF.md
# Strobed 8-bit Host Bus Slave for a Display Controller

This block sits between a host processor and the internals of a display controller. The host uses an asynchronous bus with separate active-low read and write strobes, an active-low select, a data/command line and eight bidirectional data lines. The block brings the strobes into the controller clock domain. It turns each completed host write into a one-beat stream item for the downstream logic. It answers host reads either with a status byte or with display memory contents, and it keeps a memory address that advances on every memory access.

Memory reads go through a prefetch register, because the memory has a clock of latency and the host expects data while its strobe is still low. Each memory read drives the byte that the previous memory read fetched, and then fetches the next one. After the host loads a new address, its first memory read is a throw-away. The memory, the command decoder and the logic that drives the address load are all outside the block.

Written items leave on a valid/ready port. The block holds one item. While that item waits for `wr_ready`, it stays unchanged. The host bus has no means to stall, so a write that completes while an item is still held is discarded, and the host must pace its writes to suit the consumer.

Top module: `hif8080_slave`

## Requirements
- R1: A host write (select low, write strobe low and then high again) produces one stream item only after the synchronised write strobe has returned high. The item carries the byte that was on the bus while the strobe was low, and `wr_is_data` equals the data/command line: 1 means display memory and 0 means command.
- R2: A memory write item carries the current address in `wr_addr`, and once it is accepted into the holding register the address advances by one. A command item does not move the address.
- R3: `addr_load` sets the address to `addr_value`. Every increment wraps modulo 2^ADDR_W.
- R4: A read with the data/command line low drives `status_byte`, captured at the start of the read, onto the bus.
- R5: A read with the data/command line high drives the prefetch register. It then fetches the memory word at the current address into that register, using one `ram_rd_en` pulse, and advances the address. After a load to address A, the first such read is a dummy and read n returns mem[A+n-2].
- R6: While `wr_valid` is high and `wr_ready` is low, the item fields hold steady and `wr_valid` stays high.
- R7: A write that completes while an item is still held is dropped. It produces no item and does not advance the address.
- R8: If both strobes are low together while the select is low, the write is discarded and a read that begins during it is ignored. No item is produced, no memory fetch happens and the address does not change.
- R9: Strobes that toggle while the select is high produce no item and no fetch.
- R10: The block drives the data lines only while the select and the read strobe are both low and the write strobe is high. Otherwise it leaves them at high impedance.
- R11: After reset, `wr_valid` and `ram_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host select, active low |
| host_dc | input | 1 | Data/command line, 1 = display memory |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_data | inout | 8 | Bidirectional host data lines |
| addr_load | input | 1 | Load `addr_value` into the address counter |
| addr_value | input | ADDR_W | Address to load |
| status_byte | input | 8 | Status returned on status reads |
| wr_valid | output | 1 | Stream item present |
| wr_ready | input | 1 | Consumer accepts the item |
| wr_is_data | output | 1 | Item class, 1 = memory data, 0 = command |
| wr_byte | output | 8 | Item payload |
| wr_addr | output | ADDR_W | Memory address of the item |
| ram_rd_en | output | 1 | Memory read request, data expected one clock later |
| ram_rd_addr | output | ADDR_W | Memory read address |
| ram_rd_data | input | 8 | Memory read data |

## Verification
The bench builds the block with ADDR_W = 4 and two synchroniser stages. With the small address space, a short run of writes crosses the top address and shows the wrap to zero. The two stages set how long a host strobe must last, which is what lets the bench line up overlapping strobes for the contention case. A memory model in the bench stores the accepted items. Read-back through the prefetch path then shows the one-read offset after an address load.

// File: rtl/hif_pkg.sv
package hif_pkg;
  localparam int BUS_W = 8;

  typedef enum logic {
    KIND_CMD  = 1'b0,
    KIND_DATA = 1'b1
  } hif_kind_e;

  typedef struct packed {
    hif_kind_e        kind;
    logic [BUS_W-1:0] value;
  } hif_beat_t;
endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/hif_wr_path.sv
module hif_wr_path
  import hif_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s_n,
  input  logic              wr_s_n,
  input  logic              rd_s_n,
  input  logic              dc_raw,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic [ADDR_W-1:0] addr_cur,
  input  logic              out_ready,
  output logic              out_valid,
  output hif_beat_t         out_beat,
  output logic [ADDR_W-1:0] out_addr,
  output logic              adv
);
  logic      wr_prev_q, armed_q, clash_q;
  hif_beat_t cap_q;
  logic      rise, commit, room;

  assign rise   = wr_s_n && !wr_prev_q;
  assign commit = rise && armed_q && !clash_q;
  assign room   = !out_valid || out_ready;
  assign adv    = commit && room && (cap_q.kind == KIND_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b1;
      armed_q   <= 1'b0;
      clash_q   <= 1'b0;
      cap_q     <= '0;
      out_valid <= 1'b0;
      out_beat  <= '0;
      out_addr  <= '0;
    end else begin
      wr_prev_q <= wr_s_n;
      if (!wr_s_n && !rd_s_n && !cs_s_n) clash_q <= 1'b1;
      else if (wr_s_n && rd_s_n)         clash_q <= 1'b0;
      if (!wr_s_n && !cs_s_n) begin
        armed_q <= 1'b1;
        cap_q   <= '{kind: hif_kind_e'(dc_raw), value: bus_in};
      end else if (rise) begin
        armed_q <= 1'b0;
      end
      if (commit && room) begin
        out_valid <= 1'b1;
        out_beat  <= cap_q;
        out_addr  <= addr_cur;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hif_rd_path.sv
module hif_rd_path
  import hif_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s_n,
  input  logic              wr_s_n,
  input  logic              rd_s_n,
  input  logic              dc_raw,
  input  logic [BUS_W-1:0]  status_byte,
  input  logic [BUS_W-1:0]  mem_data,
  input  logic [ADDR_W-1:0] addr_next_wr,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              adv,
  output logic [BUS_W-1:0]  drive_byte
);
  logic             rd_prev_q, fetch_q;
  logic [BUS_W-1:0] pre_q;
  logic             start;

  assign start    = !rd_s_n && rd_prev_q && !cs_s_n && wr_s_n;
  assign mem_en   = start && dc_raw;
  assign mem_addr = addr_next_wr;
  assign adv      = mem_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev_q  <= 1'b1;
      fetch_q    <= 1'b0;
      pre_q      <= '0;
      drive_byte <= '0;
    end else begin
      rd_prev_q <= rd_s_n;
      fetch_q   <= mem_en;
      if (fetch_q) pre_q <= mem_data;
      if (start)   drive_byte <= dc_raw ? pre_q : status_byte;
    end
  end
endmodule

// File: rtl/hif8080_slave.sv
module hif8080_slave
  import hif_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_dc,
  input  logic              host_wr_n,
  input  logic              host_rd_n,
  inout  wire  [7:0]        host_data,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic [7:0]        status_byte,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_is_data,
  output logic [7:0]        wr_byte,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_rd_addr,
  input  logic [7:0]        ram_rd_data
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic              cs_s, wr_s, rd_s;
  logic [ADDR_W-1:0] addr_q, addr_after_wr;
  logic              adv_w, adv_r, bus_oe;
  logic [7:0]        drive_byte;
  hif_beat_t         beat;

  hif_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({host_cs_n, host_wr_n, host_rd_n}),
    .sync_out({cs_s, wr_s, rd_s})
  );

  assign addr_after_wr = adv_w ? addr_q + ONE : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (addr_load) addr_q <= addr_value;
    else                addr_q <= adv_r ? addr_after_wr + ONE : addr_after_wr;
  end

  hif_wr_path #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .cs_s_n(cs_s), .wr_s_n(wr_s), .rd_s_n(rd_s),
    .dc_raw(host_dc), .bus_in(host_data), .addr_cur(addr_q),
    .out_ready(wr_ready), .out_valid(wr_valid), .out_beat(beat),
    .out_addr(wr_addr), .adv(adv_w)
  );

  assign wr_is_data = (beat.kind == KIND_DATA);
  assign wr_byte    = beat.value;

  hif_rd_path #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .cs_s_n(cs_s), .wr_s_n(wr_s), .rd_s_n(rd_s),
    .dc_raw(host_dc), .status_byte(status_byte),
    .mem_data(ram_rd_data), .addr_next_wr(addr_after_wr),
    .mem_en(ram_rd_en), .mem_addr(ram_rd_addr),
    .adv(adv_r), .drive_byte(drive_byte)
  );

  assign bus_oe    = !host_rd_n && !host_cs_n && host_wr_n;
  assign host_data = bus_oe ? drive_byte : 8'bz;
endmodule

// File: rtl/hif8080_chk.sv
module hif8080_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_is_data,
  input logic [7:0]        wr_byte,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              ram_rd_en,
  input logic              wr_s_n
);
  // R6
  item_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_byte) && $stable(wr_is_data) && $stable(wr_addr)));

  // R1
  trailing_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(wr_s_n));

  // R5
  single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |=> !ram_rd_en);

  // R8
  no_fetch_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |-> wr_s_n);

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!wr_valid && !ram_rd_en);
    end
  end
endmodule

bind hif8080_slave hif8080_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_is_data(wr_is_data), .wr_byte(wr_byte), .wr_addr(wr_addr),
  .ram_rd_en(ram_rd_en), .wr_s_n(wr_s)
);

// File: tb/hif8080_slave_tb_top.sv
module hif8080_slave_tb_top;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cs_n = 1'b1, dc = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic          tb_oe = 1'b0;
  logic [7:0]    tb_val = '0;
  wire  [7:0]    bus;
  logic          addr_load = 1'b0;
  logic [AW-1:0] addr_value = '0;
  logic [7:0]    status_byte = 8'h5C;
  logic          wr_valid, wr_ready = 1'b1, wr_is_data, ram_rd_en;
  logic [7:0]    wr_byte, ram_rd_data;
  logic [AW-1:0] wr_addr, ram_rd_addr;
  logic [7:0]    mem [16];

  assign bus = tb_oe ? tb_val : 8'bz;

  hif8080_slave #(.ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_dc(dc),
    .host_wr_n(wr_n), .host_rd_n(rd_n), .host_data(bus),
    .addr_load(addr_load), .addr_value(addr_value), .status_byte(status_byte),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_is_data(wr_is_data),
    .wr_byte(wr_byte), .wr_addr(wr_addr), .ram_rd_en(ram_rd_en),
    .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data)
  );

  always_ff @(posedge clk) begin
    if (wr_valid && wr_ready && wr_is_data) mem[wr_addr] <= wr_byte;
    if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];
  end

  int n_chk = 0, n_fail = 0;
  logic [12:0] exp_q[$];

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: pops the scoreboard on each handshake
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      logic [12:0] got;
      got = {wr_is_data, wr_byte, wr_addr};
      if (exp_q.size() == 0) begin
        check(1'b0, "R1/R8/R9 unexpected item", 16'(got), 16'h0);
      end else begin
        logic [12:0] want;
        want = exp_q.pop_front();
        check(got == want, "R1/R2/R3 item", 16'(got), 16'(want));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    addr_value = a; addr_load = 1'b1;
    step(1);
    addr_load = 1'b0;
    step(1);
  endtask

  task automatic host_write(input logic d, input logic [7:0] v, input logic sel_n);
    cs_n = sel_n; dc = d; tb_oe = 1'b1; tb_val = v;
    step(2); wr_n = 1'b0;
    step(6); wr_n = 1'b1;
    step(4); tb_oe = 1'b0; cs_n = 1'b1;
    step(4);
  endtask

  task automatic expect_item(input logic d, input logic [7:0] v, input logic [AW-1:0] a);
    exp_q.push_back({d, v, a});
  endtask

  task automatic host_read(input logic d, output logic [7:0] v);
    cs_n = 1'b0; dc = d;
    step(2); rd_n = 1'b0;
    step(6);
    @(negedge clk); v = bus;
    step(1); rd_n = 1'b1;
    step(4); cs_n = 1'b1;
    step(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    step(3);
    @(negedge clk);
    // R11
    check(!wr_valid && !ram_rd_en, "R11 reset outputs", {14'h0, wr_valid, ram_rd_en}, 16'h0);
    rst_n = 1'b1;
    step(2);

    // R1 R2 R3: data writes advance, command does not
    load_addr(4'd3);
    expect_item(1'b1, 8'hAA, 4'd3); host_write(1'b1, 8'hAA, 1'b0);
    expect_item(1'b1, 8'hBB, 4'd4); host_write(1'b1, 8'hBB, 1'b0);
    expect_item(1'b0, 8'h81, 4'd5); host_write(1'b0, 8'h81, 1'b0);
    expect_item(1'b1, 8'hCC, 4'd5); host_write(1'b1, 8'hCC, 1'b0);

    // R4 status read
    host_read(1'b0, rv);
    check(rv == 8'h5C, "R4 status read", 16'(rv), 16'h5C);
    status_byte = 8'hE1;
    host_read(1'b0, rv);
    check(rv == 8'hE1, "R4 status read 2", 16'(rv), 16'hE1);

    // R5 dummy read then sequential data
    load_addr(4'd3);
    host_read(1'b1, rv);
    host_read(1'b1, rv);
    check(rv == 8'hAA, "R5 first real read", 16'(rv), 16'hAA);
    host_read(1'b1, rv);
    check(rv == 8'hBB, "R5 second real read", 16'(rv), 16'hBB);
    expect_item(1'b1, 8'h9E, 4'd6); host_write(1'b1, 8'h9E, 1'b0); // R5 reads advanced address

    // R3 wrap
    load_addr(4'd15);
    expect_item(1'b1, 8'h11, 4'd15); host_write(1'b1, 8'h11, 1'b0);
    expect_item(1'b1, 8'h22, 4'd0);  host_write(1'b1, 8'h22, 1'b0);

    // R6 R7 back-pressure and drop
    load_addr(4'd7);
    wr_ready = 1'b0;
    host_write(1'b1, 8'h33, 1'b0);
    @(negedge clk);
    check(wr_valid && wr_byte == 8'h33, "R6 item held", {7'h0, wr_valid, wr_byte}, 16'h0133);
    step(1);
    host_write(1'b1, 8'h44, 1'b0);
    @(negedge clk);
    check(wr_valid && wr_byte == 8'h33 && wr_addr == 4'd7, "R7 held item kept",
          {3'h0, wr_valid, wr_addr, wr_byte}, 16'h1733);
    expect_item(1'b1, 8'h33, 4'd7);
    step(1);
    wr_ready = 1'b1;
    step(3);
    expect_item(1'b1, 8'h55, 4'd8); host_write(1'b1, 8'h55, 1'b0); // R7 no advance on drop

    // R8 both strobes low
    cs_n = 1'b0; dc = 1'b1; tb_oe = 1'b1; tb_val = 8'hEE;
    step(2); wr_n = 1'b0;
    step(4); rd_n = 1'b0;
    step(6); rd_n = 1'b1;
    step(4); wr_n = 1'b1;
    step(4); tb_oe = 1'b0; cs_n = 1'b1;
    step(4);
    check(exp_q.size() == 0 && !wr_valid, "R8 contention ignored", {15'h0, wr_valid}, 16'h0);
    expect_item(1'b1, 8'h66, 4'd9); host_write(1'b1, 8'h66, 1'b0); // R8 address unchanged

    // R9 select high
    host_write(1'b1, 8'h77, 1'b1);
    check(!wr_valid, "R9 deselected write", {15'h0, wr_valid}, 16'h0);
    expect_item(1'b1, 8'h78, 4'd10); host_write(1'b1, 8'h78, 1'b0);

    // R10 bus release
    cs_n = 1'b0; dc = 1'b0; tb_oe = 1'b1; tb_val = 8'h5A;
    step(4);
    @(negedge clk);
    check(bus == 8'h5A, "R10 released with read high", 16'(bus), 16'h5A);
    cs_n = 1'b1; rd_n = 1'b0; tb_val = 8'hC3;
    step(4);
    @(negedge clk);
    check(bus == 8'hC3, "R10 released with select high", 16'(bus), 16'hC3);
    rd_n = 1'b1; tb_oe = 1'b0;
    step(4);
    check(exp_q.size() == 0, "R1 all items seen", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule